// File: doc/BRIEF.md
# Baseband Serial Register Host

This block lets a host processor read and write the 8-bit configuration registers of an external baseband device over a four-wire serial link. The host first loads a write-data register, then writes a 16-bit control word. The upper nibble of that word chooses the operation and the low bits carry the device register address. The block raises `busy` and shifts out one frame: a read/write flag, seven address bits and eight data bits. On a read it samples the device's reply during the data phase. When the frame ends, `busy` drops, and a completed read leaves the fetched byte in a held read-data register.

The host interface is a set of plain register strobes with a `busy` status. The block has no request/acknowledge handshake. Software polls `busy` and issues a new control word only when it is low. A control word that arrives while `busy` is high is discarded. `busy` therefore acts as the only back-pressure signal. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `bb_serial_host`

## Requirements
- R1: After reset `busy`=0, `bb_csn`=1, `bb_sck`=0, `bb_mosi`=0 and `rd_byte`=0x00.
- R2: A control word whose bits [15:12] equal 0x5 starts a write. The frame sent MSB first is flag 0, then address bits [6:0], then the byte held in the write-data register.
- R3: A control word whose bits [15:12] equal 0x6 starts a read. The frame is flag 1, then address bits [6:0], then eight 0 bits on `bb_mosi`. The eight `bb_miso` values sampled on the last eight SCK rising edges form the byte, MSB first, and that byte appears in `rd_byte` when `busy` falls.
- R4: A control word with any other value in bits [15:12] is ignored: `busy` stays 0, `bb_csn` stays 1 and no frame is sent.
- R5: A control word written while `busy` is 1 is dropped. The running frame and its length are unchanged, and no second frame follows.
- R6: `busy` rises in the cycle after the accepted control write and stays high for exactly 32*HALF_DIV cycles. `bb_csn` is low exactly while `busy` is high.
- R7: SCK idles low. Each of the 16 bits holds SCK low for HALF_DIV cycles and then high for HALF_DIV cycles. `bb_mosi` changes only while SCK is low or at a falling edge.
- R8: The data byte is captured when the transfer starts. Writing the write-data register during a transfer does not alter that frame, and the new value is used by later writes.
- R9: `rd_byte` changes only when a read transfer completes. Write transfers and an unfinished read leave it unchanged.
- R10: Control bits [11:8] and address bit 7 are not transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control word: opcode [15:12], address [7:0] |
| wdat_we | input | 1 | Write-data register strobe |
| wdat_wdata | input | 8 | Byte for the next register write |
| busy | output | 1 | Transfer in progress |
| rd_byte | output | 8 | Byte returned by the last completed read |
| bb_sck | output | 1 | Serial clock to the device |
| bb_csn | output | 1 | Active-low frame select |
| bb_mosi | output | 1 | Serial data to the device |
| bb_miso | input | 1 | Serial data from the device |

## Verification
The assertions assume that `bb_miso` is settled by each SCK rising edge and that the host holds `ctrl_we` for single cycles. They make no assumption about when control writes arrive relative to `busy`. The stimulus therefore deliberately issues control writes and write-data updates in the middle of a frame. The bench's device model changes `bb_miso` only on SCK falling edges. Random operations draw their addresses from 0 to 0x68 and also set the ignored control bits, so the dropped-address-bit and opcode-decode paths are exercised alongside ordinary transfers.

// File: rtl/bbsif_pkg.sv
package bbsif_pkg;
  localparam int unsigned OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_WRITE = 4'h5;
  localparam logic [OPC_W-1:0] OPC_READ  = 4'h6;

  typedef enum logic [1:0] {
    BB_OP_NONE  = 2'd0,
    BB_OP_WRITE = 2'd1,
    BB_OP_READ  = 2'd2
  } bb_op_e;
endpackage

// File: rtl/bbsif_decode.sv
module bbsif_decode
  import bbsif_pkg::*;
#(
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned ADDR_W = 7
) (
  input  logic [CTRL_W-1:0] ctrl,
  output bb_op_e            op,
  output logic [ADDR_W-1:0] addr
);
  logic [OPC_W-1:0] opc;

  assign opc  = ctrl[CTRL_W-1 -: OPC_W];
  assign addr = ctrl[ADDR_W-1:0];

  always_comb begin
    case (opc)
      OPC_WRITE: op = BB_OP_WRITE;
      OPC_READ:  op = BB_OP_READ;
      default:   op = BB_OP_NONE;
    endcase
  end
endmodule

// File: rtl/bbsif_sck_gen.sv
module bbsif_sck_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sck,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          phase_end;

  assign phase_end = run && (cnt == CNT_LAST);
  assign rise_tick = phase_end && !sck;
  assign fall_tick = phase_end && sck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (run) begin
      if (cnt == CNT_LAST) begin
        cnt <= '0;
        sck <= ~sck;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck);
endmodule

// File: rtl/bbsif_shift.sv
module bbsif_shift #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              miso,
  input  logic              rise_tick,
  input  logic              fall_tick,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int unsigned BCW     = $clog2(FRAME_W + 1);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(FRAME_W);

  logic [FRAME_W-1:0] tx_sh;
  logic [DATA_W-1:0]  rx_sh;
  logic [BCW-1:0]     bitcnt;

  assign mosi    = tx_sh[FRAME_W-1];
  assign rx_byte = rx_sh;
  assign done    = fall_tick && (bitcnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      bitcnt <= '0;
    end else if (start) begin
      tx_sh  <= {is_read, addr, (is_read ? {DATA_W{1'b0}} : wdata)};
      bitcnt <= '0;
    end else begin
      if (rise_tick) begin
        bitcnt <= bitcnt + 1'b1;
        rx_sh  <= {rx_sh[DATA_W-2:0], miso};
      end
      if (fall_tick) begin
        if (bitcnt == BIT_LAST) tx_sh <= '0;
        else                    tx_sh <= tx_sh << 1;
      end
    end
  end

  // R7
  bit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (bitcnt < BIT_LAST));
endmodule

// File: rtl/bb_serial_host.sv
module bb_serial_host
  import bbsif_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned CTRL_W   = 16,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              wdat_we,
  input  logic [DATA_W-1:0] wdat_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rd_byte,
  output logic              bb_sck,
  output logic              bb_csn,
  output logic              bb_mosi,
  input  logic              bb_miso
);
  bb_op_e            op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rx_byte;
  logic              start, done, rise_tick, fall_tick;
  logic              rd_pend;

  bbsif_decode #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W)) u_dec (
    .ctrl(ctrl_wdata), .op(op), .addr(addr)
  );

  assign start = ctrl_we && !busy && (op != BB_OP_NONE);

  bbsif_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
    .sck(bb_sck), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  bbsif_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .start(start),
    .is_read(op == BB_OP_READ), .addr(addr), .wdata(wdat_q),
    .miso(bb_miso), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mosi(bb_mosi), .done(done), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wdat_q <= '0;
    else if (wdat_we) wdat_q <= wdat_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bb_csn  <= 1'b1;
      rd_pend <= 1'b0;
      rd_byte <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      bb_csn  <= 1'b0;
      rd_pend <= (op == BB_OP_READ);
    end else if (done) begin
      busy    <= 1'b0;
      bb_csn  <= 1'b1;
      if (rd_pend) rd_byte <= rx_byte;
    end
  end

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !busy && (ctrl_wdata[CTRL_W-1 -: OPC_W] == OPC_WRITE ||
     ctrl_wdata[CTRL_W-1 -: OPC_W] == OPC_READ)) |=> busy);
  // R4
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !busy && ctrl_wdata[CTRL_W-1 -: OPC_W] != OPC_WRITE &&
     ctrl_wdata[CTRL_W-1 -: OPC_W] != OPC_READ) |=> (!busy && bb_csn));
  // R6
  csn_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bb_csn == !busy);
  // R5
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_we && !done) |=> busy);
  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_sck && $past(bb_sck)) |-> $stable(bb_mosi));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(rd_byte));
endmodule

// File: tb/test_bb_serial_host.sv
module test_bb_serial_host;
  localparam int HALF = 2;
  localparam int XFER = 32 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, wdat_we = 1'b0, bb_miso = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [7:0]  wdat_wdata = '0;
  logic busy, bb_sck, bb_csn, bb_mosi;
  logic [7:0] rd_byte;

  int checks = 0, fails = 0;
  logic [7:0] dev_mem [128];
  logic [7:0] exp_mem [128];

  always #4 clk = ~clk;

  bb_serial_host #(.HALF_DIV(HALF)) i_bb_serial_host (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .wdat_we(wdat_we), .wdat_wdata(wdat_wdata), .busy(busy),
    .rd_byte(rd_byte), .bb_sck(bb_sck), .bb_csn(bb_csn),
    .bb_mosi(bb_mosi), .bb_miso(bb_miso)
  );

  // device model
  int dev_cnt = 0, nframes = 0;
  logic [15:0] dev_sh = '0, last_frame = '0;
  logic dev_rw = 1'b0;
  logic [6:0] dev_addr = '0;
  always @(negedge bb_csn) dev_cnt = 0;
  always @(posedge bb_sck) if (!bb_csn) begin
    dev_sh = {dev_sh[14:0], bb_mosi};
    dev_cnt++;
    if (dev_cnt == 8) begin dev_rw = dev_sh[7]; dev_addr = dev_sh[6:0]; end
  end
  always @(negedge bb_sck) if (!bb_csn && dev_rw && dev_cnt >= 8 && dev_cnt < 16)
    bb_miso = dev_mem[dev_addr][15 - dev_cnt];
  always @(posedge bb_csn) if (dev_cnt == 16) begin
    last_frame = dev_sh;
    nframes++;
    if (!dev_sh[15]) dev_mem[dev_sh[14:8]] = dev_sh[7:0];
  end

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 37) ^ 8'h5A);
  endfunction
  function automatic logic [15:0] exp_frame(logic rw, logic [7:0] a, logic [7:0] d);
    return {rw, a[6:0], rw ? 8'h00 : d};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_wdata(input logic [7:0] d);
    @(negedge clk); wdat_we = 1'b1; wdat_wdata = d;
    @(negedge clk); wdat_we = 1'b0;
  endtask

  // issue control word; count busy cycles; check busy rise and rd_byte hold
  task automatic run_op(input logic [15:0] cw, output int ncyc);
    logic [7:0] rd0;
    rd0 = rd_byte;
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = cw;
    @(negedge clk); ctrl_we = 1'b0;
    chk(busy == 1'b1 && bb_csn == 1'b0, "R6 busy rise", {busy, bb_csn}, 2'b10);
    ncyc = 0;
    while (busy && ncyc < 1000) begin
      ncyc++;
      if (ncyc == XFER / 2) chk(rd_byte == rd0, "R9 mid-transfer hold", rd_byte, rd0);
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [15:0] cw, input logic [7:0] d);
    int n, f0;
    logic [7:0] r0;
    set_wdata(d);
    f0 = nframes; r0 = rd_byte;
    run_op(cw, n);
    chk(n == XFER, "R6 busy length", n, XFER);
    chk(nframes == f0 + 1 && last_frame == exp_frame(1'b0, cw[7:0], d),
        "R2 write frame", last_frame, exp_frame(1'b0, cw[7:0], d));
    chk(rd_byte == r0, "R9 write keeps rd_byte", rd_byte, r0);
    exp_mem[cw[6:0]] = d;
  endtask

  task automatic do_read(input logic [15:0] cw);
    int n;
    run_op(cw, n);
    chk(n == XFER, "R6 busy length", n, XFER);
    chk(last_frame == exp_frame(1'b1, cw[7:0], 8'h00), "R3 read frame",
        last_frame, exp_frame(1'b1, cw[7:0], 8'h00));
    chk(rd_byte == exp_mem[cw[6:0]], "R3 read data", rd_byte, exp_mem[cw[6:0]]);
  endtask

  task automatic do_bad(input logic [15:0] cw);
    int f0; logic seen;
    f0 = nframes; seen = 1'b0;
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = cw;
    @(negedge clk); ctrl_we = 1'b0;
    for (int i = 0; i < 70; i++) begin
      if (busy || !bb_csn) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen && nframes == f0, "R4 bad opcode ignored", {seen, 8'(nframes - f0)}, 0);
  endtask

  initial begin
    int n, f0;
    for (int a = 0; a < 128; a++) begin dev_mem[a] = init_val(a); exp_mem[a] = init_val(a); end
    repeat (3) @(negedge clk);
    chk(busy == 0 && bb_csn == 1 && bb_sck == 0 && bb_mosi == 0 && rd_byte == 0,
        "R1 reset state", {busy, bb_csn, bb_sck, bb_mosi, rd_byte}, 12'h400);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_write(16'h5000, 8'hA5);
    do_read(16'h6068);
    do_read(16'h6000);
    // R10: ignored bits [11:8] and address bit 7
    do_write(16'h5F85, 8'h3C);
    do_read(16'h6A85);
    do_bad(16'h0012);
    do_bad(16'h7012);
    do_bad(16'h4012);
    do_bad(16'hF068);

    // R5 and R8: control and data writes during a transfer
    set_wdata(8'h96);
    f0 = nframes;
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 16'h5010;
    @(negedge clk); ctrl_we = 1'b0;
    n = 1;
    repeat (5) begin @(negedge clk); n++; end
    ctrl_we = 1'b1; ctrl_wdata = 16'h6011; wdat_we = 1'b1; wdat_wdata = 8'hE1;
    @(negedge clk); ctrl_we = 1'b0; wdat_we = 1'b0; n++;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    n--;
    chk(n == XFER, "R5 busy length with dropped write", n, XFER);
    chk(last_frame == exp_frame(1'b0, 8'h10, 8'h96), "R8 frame keeps start data",
        last_frame, exp_frame(1'b0, 8'h10, 8'h96));
    exp_mem[7'h10] = 8'h96;
    repeat (80) @(negedge clk);
    chk(nframes == f0 + 1, "R5 no second frame", nframes - f0, 1);
    // new data value used by next write without reload
    f0 = nframes;
    run_op(16'h5020, n);
    chk(last_frame == exp_frame(1'b0, 8'h20, 8'hE1), "R8 later write uses new data",
        last_frame, exp_frame(1'b0, 8'h20, 8'hE1));
    exp_mem[7'h20] = 8'hE1;
    do_read(16'h6010);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a; logic [3:0] hi; int sel;
      a = 8'($urandom_range(0, 8'h68)) | ($urandom_range(0, 1) ? 8'h80 : 8'h00);
      hi = 4'($urandom_range(0, 15));
      sel = $urandom_range(0, 9);
      if (sel < 4)      do_write({4'h5, hi, a}, 8'($urandom));
      else if (sel < 8) do_read({4'h6, hi, a});
      else              do_bad({4'h3, hi, a});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule